// File: doc/BRIEF.md
# DSP Accumulator ALU and Multiplier

This block is the arithmetic core of a 16-bit signal processor. It holds a 32-bit accumulator, two 16-bit multiplier operand registers (X and Y), a 32-bit product register, and the zero and negative flags. An outside sequencer issues one operation per clock. Each operation carries an operation kind, a function field, a condition selector with an expected flag bit, a 16-bit operand, and fresh X/Y values.

Sixteen-bit ALU operands act on the upper half of the accumulator: the operand is placed in bits 31:16 with zeros below and then combined with all 32 bits. The product register always holds twice the signed product of X and Y, one clock behind them. Multiply steps clear, add to or subtract from the accumulator using the product already in place, and load new X and Y in the same cycle. Move operations write either half of the accumulator and leave the flags alone. A conditional modify step can shift, negate or take the absolute value of the accumulator.

Top module: `dsp_acc_mac`

## Requirements
- R1: After reset, the accumulator, product, X, Y, flagZ and flagN are all zero.
- R2: With opKind=1 (ALU), the value {operand,16'h0} is combined with the full accumulator according to aluFn: 1 subtract, 4 add, 5 AND, 6 OR, 7 XOR. aluFn values 0 and 2 change neither the accumulator nor the flags.
- R3: With opKind=1 and aluFn=3 (compare), the flags are set from accumulator minus {operand,16'h0}, and the accumulator is unchanged.
- R4: Every operation that updates flags sets flagZ when all 32 result bits are zero, and sets flagN to bit 31 of the result.
- R5: The product register equals the sign-extended X times the sign-extended Y, times two, truncated to 32 bits. It takes the value of the X and Y present one clock earlier.
- R6: With opKind=2 (multiply-load), the accumulator becomes zero with flagZ=1 and flagN=0, and X and Y load xIn and yIn.
- R7: With opKind=3 the accumulator gains the product value held before the clock edge, and with opKind=4 it loses that value. Both load X/Y from xIn/yIn and update the flags.
- R8: With opKind=5 and a true condition, modFn selects the change: 2 arithmetic shift right by one, 3 shift left by one, 6 negate, 7 absolute value. The flags then update. Any other modFn leaves the accumulator and the flags unchanged.
- R9: condSel=0 is always true, condSel=5 is true when flagZ equals condFlag, condSel=7 is true when flagN equals condFlag, and every other code is false. A false condition changes nothing.
- R10: opKind=6 writes the operand into accumulator bits 31:16 and opKind=7 writes it into bits 15:0. The other half is kept, and the flags are unchanged.
- R11: xLoad and yLoad each load their own operand register from xIn or yIn when no multiply step is issued. Multiply steps load both registers whatever the strobes are.
- R12: Accumulator arithmetic wraps modulo 2^32, with no saturation.
- R13: opKind=0 changes no register other than the product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opKind | input | 3 | Operation kind: 0 none, 1 ALU, 2 mult-load, 3 mult-add, 4 mult-sub, 5 modify, 6 write high, 7 write low |
| aluFn | input | 3 | ALU function code |
| modFn | input | 3 | Modify function code |
| condSel | input | 4 | Condition selector for modify |
| condFlag | input | 1 | Expected flag value for the condition |
| operand | input | 16 | ALU and move operand |
| xIn | input | 16 | New X value |
| yIn | input | 16 | New Y value |
| xLoad | input | 1 | Load X from xIn |
| yLoad | input | 1 | Load Y from yIn |
| accHi | output | 16 | Accumulator bits 31:16 |
| accLo | output | 16 | Accumulator bits 15:0 |
| prod | output | 32 | Product register |
| xOut | output | 16 | X register |
| yOut | output | 16 | Y register |
| flagZ | output | 1 | Zero flag |
| flagN | output | 1 | Negative flag |

## Verification
The product check assumes reset is held for at least two clocks, so that the product and the operand registers start out in step. The bench always holds reset for four edges. The checks on a single operation assume each operation lasts exactly one clock and that the inputs settle between edges. The stimulus drives every field on the falling edge and repeats no operation by accident. Since an accumulate step uses the product of the X/Y loaded one cycle earlier, the stimulus puts an idle cycle between a load and the accumulate that depends on it.

// File: rtl/accmac_pkg.sv
package accmac_pkg;
  typedef enum logic [2:0] {
    K_NOP  = 3'd0,
    K_ALU  = 3'd1,
    K_MLD  = 3'd2,
    K_MPYA = 3'd3,
    K_MPYS = 3'd4,
    K_MOD  = 3'd5,
    K_WRHI = 3'd6,
    K_WRLO = 3'd7
  } opKind_e;

  typedef enum logic [2:0] {
    S_ALU, S_CLR, S_ADDP, S_SUBP, S_MOD, S_HI, S_LO
  } accSrc_e;

  typedef struct packed {
    logic       accWr;
    logic       flagWr;
    accSrc_e    accSrc;
    logic [2:0] aluFn;
    logic [2:0] modFn;
    logic       xWr;
    logic       yWr;
    logic       xyMac;
  } dpCtl_t;
endpackage

// File: rtl/accmac_ctrl.sv
module accmac_ctrl
  import accmac_pkg::*;
(
  input  logic [2:0] opKind,
  input  logic [2:0] aluFn,
  input  logic [2:0] modFn,
  input  logic [3:0] condSel,
  input  logic       condFlag,
  input  logic       xLoad,
  input  logic       yLoad,
  input  logic       flagZ,
  input  logic       flagN,
  output dpCtl_t     ctl
);
  logic condTrue;
  logic aluKnown;
  logic modKnown;

  always_comb begin
    case (condSel)
      4'd0:    condTrue = 1'b1;
      4'd5:    condTrue = (flagZ == condFlag);
      4'd7:    condTrue = (flagN == condFlag);
      default: condTrue = 1'b0;
    endcase
  end

  assign aluKnown = (aluFn != 3'd0) && (aluFn != 3'd2);
  assign modKnown = (modFn == 3'd2) || (modFn == 3'd3) ||
                    (modFn == 3'd6) || (modFn == 3'd7);

  always_comb begin
    ctl        = '0;
    ctl.accSrc = S_ALU;
    ctl.aluFn  = aluFn;
    ctl.modFn  = modFn;
    ctl.xWr    = xLoad;
    ctl.yWr    = yLoad;
    case (opKind_e'(opKind))
      K_ALU: begin
        ctl.flagWr = aluKnown;
        ctl.accWr  = aluKnown && (aluFn != 3'd3);
      end
      K_MLD, K_MPYA, K_MPYS: begin
        ctl.accSrc = (opKind_e'(opKind) == K_MLD)  ? S_CLR :
                     (opKind_e'(opKind) == K_MPYA) ? S_ADDP : S_SUBP;
        ctl.accWr  = 1'b1;
        ctl.flagWr = 1'b1;
        ctl.xyMac  = 1'b1;
      end
      K_MOD: begin
        ctl.accSrc = S_MOD;
        ctl.accWr  = condTrue && modKnown;
        ctl.flagWr = condTrue && modKnown;
      end
      K_WRHI: begin
        ctl.accSrc = S_HI;
        ctl.accWr  = 1'b1;
      end
      K_WRLO: begin
        ctl.accSrc = S_LO;
        ctl.accWr  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/accmac_dp.sv
module accmac_dp
  import accmac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpCtl_t                ctl,
  input  logic [DATA_W-1:0]     operand,
  input  logic [DATA_W-1:0]     xIn,
  input  logic [DATA_W-1:0]     yIn,
  output logic [2*DATA_W-1:0]   acc,
  output logic [2*DATA_W-1:0]   prodR,
  output logic [DATA_W-1:0]     xR,
  output logic [DATA_W-1:0]     yR,
  output logic                  zF,
  output logic                  nF
);
  localparam int ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0] operandHi;
  logic [ACC_W-1:0] aluRes;
  logic [ACC_W-1:0] modRes;
  logic [ACC_W-1:0] nextAcc;
  logic [ACC_W-1:0] xExt;
  logic [ACC_W-1:0] yExt;
  logic [ACC_W-1:0] mulRaw;
  logic [ACC_W-1:0] prodNext;

  assign operandHi = {operand, {DATA_W{1'b0}}};

  always_comb begin
    case (ctl.aluFn)
      3'd1, 3'd3: aluRes = acc - operandHi;
      3'd4:       aluRes = acc + operandHi;
      3'd5:       aluRes = acc & operandHi;
      3'd6:       aluRes = acc | operandHi;
      3'd7:       aluRes = acc ^ operandHi;
      default:    aluRes = acc;
    endcase
  end

  always_comb begin
    case (ctl.modFn)
      3'd2:    modRes = {acc[ACC_W-1], acc[ACC_W-1:1]};
      3'd3:    modRes = {acc[ACC_W-2:0], 1'b0};
      3'd6:    modRes = '0 - acc;
      3'd7:    modRes = acc[ACC_W-1] ? ('0 - acc) : acc;
      default: modRes = acc;
    endcase
  end

  always_comb begin
    case (ctl.accSrc)
      S_ALU:   nextAcc = aluRes;
      S_CLR:   nextAcc = '0;
      S_ADDP:  nextAcc = acc + prodR;
      S_SUBP:  nextAcc = acc - prodR;
      S_MOD:   nextAcc = modRes;
      S_HI:    nextAcc = {operand, acc[DATA_W-1:0]};
      S_LO:    nextAcc = {acc[ACC_W-1:DATA_W], operand};
      default: nextAcc = acc;
    endcase
  end

  assign xExt     = {{DATA_W{xR[DATA_W-1]}}, xR};
  assign yExt     = {{DATA_W{yR[DATA_W-1]}}, yR};
  assign mulRaw   = xExt * yExt;
  assign prodNext = {mulRaw[ACC_W-2:0], 1'b0};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      acc   <= '0;
      prodR <= '0;
      xR    <= '0;
      yR    <= '0;
      zF    <= 1'b0;
      nF    <= 1'b0;
    end else begin
      prodR <= prodNext;
      if (ctl.accWr) acc <= nextAcc;
      if (ctl.flagWr) begin
        zF <= (nextAcc == '0);
        nF <= nextAcc[ACC_W-1];
      end
      if (ctl.xyMac || ctl.xWr) xR <= xIn;
      if (ctl.xyMac || ctl.yWr) yR <= yIn;
    end
  end
endmodule

// File: rtl/dsp_acc_mac.sv
module dsp_acc_mac
  import accmac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          opKind,
  input  logic [2:0]          aluFn,
  input  logic [2:0]          modFn,
  input  logic [3:0]          condSel,
  input  logic                condFlag,
  input  logic [DATA_W-1:0]   operand,
  input  logic [DATA_W-1:0]   xIn,
  input  logic [DATA_W-1:0]   yIn,
  input  logic                xLoad,
  input  logic                yLoad,
  output logic [DATA_W-1:0]   accHi,
  output logic [DATA_W-1:0]   accLo,
  output logic [2*DATA_W-1:0] prod,
  output logic [DATA_W-1:0]   xOut,
  output logic [DATA_W-1:0]   yOut,
  output logic                flagZ,
  output logic                flagN
);
  localparam int ACC_W = 2 * DATA_W;

  dpCtl_t           ctl;
  logic [ACC_W-1:0] acc;

  accmac_ctrl u_ctrl (
    .opKind   (opKind),
    .aluFn    (aluFn),
    .modFn    (modFn),
    .condSel  (condSel),
    .condFlag (condFlag),
    .xLoad    (xLoad),
    .yLoad    (yLoad),
    .flagZ    (flagZ),
    .flagN    (flagN),
    .ctl      (ctl)
  );

  accmac_dp #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .operand (operand),
    .xIn     (xIn),
    .yIn     (yIn),
    .acc     (acc),
    .prodR   (prod),
    .xR      (xOut),
    .yR      (yOut),
    .zF      (flagZ),
    .nF      (flagN)
  );

  assign accHi = acc[ACC_W-1:DATA_W];
  assign accLo = acc[DATA_W-1:0];
endmodule

// File: rtl/accmac_chk.sv
module accmac_chk #(
  parameter int DATA_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          opKind,
  input logic [2:0]          aluFn,
  input logic [DATA_W-1:0]   xIn,
  input logic                xLoad,
  input logic [DATA_W-1:0]   accHi,
  input logic [DATA_W-1:0]   accLo,
  input logic [2*DATA_W-1:0] prod,
  input logic [DATA_W-1:0]   xOut,
  input logic [DATA_W-1:0]   yOut,
  input logic                flagZ,
  input logic                flagN
);
  localparam int ACC_W = 2 * DATA_W;

  logic [ACC_W-1:0] xS;
  logic [ACC_W-1:0] yS;
  logic [ACC_W-1:0] twiceXY;

  assign xS      = {{DATA_W{xOut[DATA_W-1]}}, xOut};
  assign yS      = {{DATA_W{yOut[DATA_W-1]}}, yOut};
  assign twiceXY = (xS * yS) << 1;

  // R5
  prod_tracks_chk: assert property (@(posedge clk) disable iff (!rstN)
    prod == $past(twiceXY));

  // R6
  mld_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    opKind == 3'd2 |=> ({accHi, accLo} == '0) && flagZ && !flagN);

  // R10
  move_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == 3'd6 || opKind == 3'd7) |=> $stable(flagZ) && $stable(flagN));

  // R3
  cmp_keeps_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == 3'd1 && aluFn == 3'd3) |=> $stable(accHi) && $stable(accLo));

  // R4
  add_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opKind == 3'd1 && aluFn == 3'd4) |=>
      (flagN == accHi[DATA_W-1]) && (flagZ == ({accHi, accLo} == '0)));

  // R11
  xload_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xLoad && (opKind < 3'd2 || opKind > 3'd4)) |=> xOut == $past(xIn));
endmodule

bind dsp_acc_mac accmac_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_dsp_acc_mac.sv
`timescale 1ns/1ps
module sim_dsp_acc_mac;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opKind = '0, aluFn = '0, modFn = '0;
  logic [3:0]  condSel = '0;
  logic        condFlag = 1'b0;
  logic [15:0] operand = '0, xIn = '0, yIn = '0;
  logic        xLoad = 1'b0, yLoad = 1'b0;
  logic [15:0] accHi, accLo, xOut, yOut;
  logic [31:0] prod;
  logic        flagZ, flagN;

  always #2.5 clk = ~clk;

  dsp_acc_mac u0 (.*);

  typedef struct {
    logic [31:0] a;
    logic [31:0] p;
    logic [15:0] x;
    logic [15:0] y;
    logic        z;
    logic        n;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] mA = '0, mP = '0;
  logic [15:0] mX = '0, mY = '0;
  logic        mZ = 1'b0, mN = 1'b0;

  function automatic logic [31:0] twice(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] ea, eb;
    ea = {{16{a[15]}}, a};
    eb = {{16{b[15]}}, b};
    return (ea * eb) << 1;
  endfunction

  task automatic step(input logic [2:0] k, input logic [2:0] af, input logic [2:0] mf,
                      input logic [3:0] cs, input logic cf, input logic [15:0] opd,
                      input logic [15:0] xi, input logic [15:0] yi,
                      input logic xl, input logic yl, input string tag);
    logic [31:0] hi, res, pNew;
    logic        fl, wr, ok;
    expItem_t    e;
    @(negedge clk);
    opKind = k; aluFn = af; modFn = mf; condSel = cs; condFlag = cf;
    operand = opd; xIn = xi; yIn = yi; xLoad = xl; yLoad = yl;
    hi = {opd, 16'h0};
    pNew = twice(mX, mY);
    res = mA; fl = 1'b0; wr = 1'b0;
    case (k)
      3'd1: begin
        fl = 1'b1; wr = 1'b1;
        case (af)
          3'd1: res = mA - hi;
          3'd3: begin res = mA - hi; wr = 1'b0; end
          3'd4: res = mA + hi;
          3'd5: res = mA & hi;
          3'd6: res = mA | hi;
          3'd7: res = mA ^ hi;
          default: begin fl = 1'b0; wr = 1'b0; end
        endcase
      end
      3'd2: begin res = 32'h0; fl = 1'b1; wr = 1'b1; end
      3'd3: begin res = mA + mP; fl = 1'b1; wr = 1'b1; end
      3'd4: begin res = mA - mP; fl = 1'b1; wr = 1'b1; end
      3'd5: begin
        ok = (cs == 4'd0) || (cs == 4'd5 && mZ == cf) || (cs == 4'd7 && mN == cf);
        if (ok) begin
          fl = 1'b1; wr = 1'b1;
          case (mf)
            3'd2: res = $unsigned($signed(mA) >>> 1);
            3'd3: res = mA << 1;
            3'd6: res = -mA;
            3'd7: res = mA[31] ? -mA : mA;
            default: begin fl = 1'b0; wr = 1'b0; end
          endcase
        end
      end
      3'd6: begin res = {opd, mA[15:0]}; wr = 1'b1; end
      3'd7: begin res = {mA[31:16], opd}; wr = 1'b1; end
      default: ;
    endcase
    if (fl) begin mZ = (res == 32'h0); mN = res[31]; end
    if (wr) mA = res;
    if (k >= 3'd2 && k <= 3'd4) begin mX = xi; mY = yi; end
    else begin
      if (xl) mX = xi;
      if (yl) mY = yi;
    end
    mP = pNew;
    e.a = mA; e.p = mP; e.x = mX; e.y = mY; e.z = mZ; e.n = mN; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    step(3'd0, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic alu(input logic [2:0] f, input logic [15:0] v, input string tag);
    step(3'd1, f, 3'd0, 4'd0, 1'b0, v, 16'h0, 16'h0, 1'b0, 1'b0, tag);
  endtask

  task automatic modify(input logic [3:0] cs, input logic cf, input logic [2:0] f, input string tag);
    step(3'd5, 3'd0, f, cs, cf, 16'h0, 16'h0, 16'h0, 1'b0, 1'b0, tag);
  endtask

  // monitor: compares each queued expectation one step after its edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if ({accHi, accLo} !== e.a || prod !== e.p || xOut !== e.x || yOut !== e.y ||
            flagZ !== e.z || flagN !== e.n) begin
          fails++;
          $display("FAIL %s: actual A=%h P=%h X=%h Y=%h Z=%b N=%b expected A=%h P=%h X=%h Y=%h Z=%b N=%b",
                   e.tag, {accHi, accLo}, prod, xOut, yOut, flagZ, flagN,
                   e.a, e.p, e.x, e.y, e.z, e.n);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    idle("R1 reset state");
    step(3'd6, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0001, 16'h0, 16'h0, 1'b0, 1'b0, "R10 write high");
    step(3'd7, 3'd0, 3'd0, 4'd0, 1'b0, 16'h8000, 16'h0, 16'h0, 1'b0, 1'b0, "R10 write low");
    alu(3'd4, 16'h7fff, "R2 R4 add sets N");
    alu(3'd3, 16'h8000, "R3 compare");
    alu(3'd1, 16'h8000, "R2 subtract");
    alu(3'd5, 16'h0000, "R2 R4 and to zero");
    alu(3'd0, 16'h1234, "R2 undefined code 0");
    alu(3'd6, 16'hffff, "R2 or");
    alu(3'd2, 16'h1111, "R2 undefined code 2");
    step(3'd6, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0000, 16'h0, 16'h0, 1'b0, 1'b0, "R10 move keeps flags");
    alu(3'd7, 16'hffff, "R2 xor");
    step(3'd7, 3'd0, 3'd0, 4'd0, 1'b0, 16'hffff, 16'h0, 16'h0, 1'b0, 1'b0, "R10 write low all ones");
    alu(3'd4, 16'h0001, "R12 add wraps");
    modify(4'd0, 1'b0, 3'd3, "R8 shift left");
    modify(4'd7, 1'b1, 3'd6, "R9 N condition false");
    modify(4'd5, 1'b0, 3'd6, "R8 R9 negate on Z match");
    modify(4'd0, 1'b0, 3'd2, "R8 arithmetic shift right");
    modify(4'd7, 1'b1, 3'd7, "R8 R9 abs on N match");
    modify(4'd3, 1'b0, 3'd6, "R9 unknown condition");
    modify(4'd0, 1'b0, 3'd4, "R8 unknown modify code");
    step(3'd0, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0, 16'h0003, 16'hfffe, 1'b1, 1'b0, "R11 load X only");
    step(3'd0, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0, 16'h5555, 16'hfffe, 1'b0, 1'b1, "R11 load Y only");
    idle("R5 product follows X Y");
    step(3'd2, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0, 16'h4000, 16'h4000, 1'b0, 1'b0, "R6 multiply load");
    idle("R5 product settles");
    step(3'd3, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0, 16'hffff, 16'h0001, 1'b1, 1'b0, "R7 multiply add");
    idle("R5 negative product");
    step(3'd4, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0, 16'h8000, 16'h8000, 1'b0, 1'b1, "R7 multiply subtract");
    step(3'd3, 3'd0, 3'd0, 4'd0, 1'b0, 16'h0, 16'h0002, 16'h0003, 1'b0, 1'b0, "R7 R12 back to back add");
    idle("R13 idle keeps state");
    idle("R5 product steady");
    while (expQ.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule